// File: doc/BRIEF.md
# Sensor Sample Packing FIFO

This block receives a stream of 16-bit sensor samples, each carrying a one-bit type tag and a valid strobe, in a slow sensor clock domain (nominally 16 MHz, one sample per clock). It groups every four accepted samples into one 64-bit word and moves that word into a faster, unrelated core clock domain (nominally half of a 33 MHz bus clock). The word goes through a small asynchronous FIFO whose pointers cross the boundary in Gray code.

On the core side a memory controller takes the words with a valid/ready handshake. The four type tags of each word travel beside it as a 4-bit sideband. A word that completes while the FIFO is full is dropped, and a sticky overflow flag in the sensor domain records the loss. Each domain has its own synchronous active-low reset. The bench holds both resets together. After that reset the queue is empty and the next word written is the first one read.

Top module: `sensor_pack_fifo`

## Requirements
- R1: After both resets have been held low together, `out_valid`, `wr_full` and `wr_overflow` are low. A partly gathered group is discarded. The first word read after the reset is the first group of four samples accepted after the reset.
- R2: A sample presented with `in_valid` low is ignored. It neither enters a word nor counts toward the group of four.
- R3: Accepted samples fill a word in arrival order. The first lands in `out_data[15:0]`, the second in [31:16], the third in [47:32] and the fourth in [63:48].
- R4: Bit i of `out_tags` is the `in_tag` value of the (i+1)-th sample of the word, so the first sample's tag is bit 0.
- R5: Words leave in the order they were completed, each exactly once. `out_valid` is high whenever an unread word is queued. A word is consumed on the core clock edge where `out_valid` and `out_ready` are both high. Until then `out_data` and `out_tags` hold steady.
- R6: `wr_full` is high once 2^AW words (8 by default) are queued unread. A word completed while `wr_full` is high is dropped and sets `wr_overflow`. The flag stays high until reset. `wr_full` falls again after the reader drains words.
- R7: `out_ready` asserted while `out_valid` is low has no effect. No word is skipped, and the next word written is delivered intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | Sensor-side clock |
| in_rst_n | input | 1 | Synchronous active-low reset, sensor side |
| in_data | input | 16 | Sample data |
| in_tag | input | 1 | Sample type tag |
| in_valid | input | 1 | Sample strobe; high means accept this sample |
| wr_full | output | 1 | Queue full, sensor side |
| wr_overflow | output | 1 | Sticky: a completed word was dropped |
| core_clk | input | 1 | Core-side clock |
| core_rst_n | input | 1 | Synchronous active-low reset, core side |
| out_valid | output | 1 | A word is available |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_data | output | 64 | Packed four-sample word |
| out_tags | output | 4 | Tags of the four samples |

## Verification
A lane counter that slips shows up on the first word after the slip, as samples rotated between 16-bit fields and tags moved between sideband bits. A bad read pointer shows up as a repeated, skipped or stale word on the next handshake. A read pointer left nonzero by reset raises `out_valid` over a slot that was never written, or delivers the wrong word first. A wrong full comparison or a missed overflow shows up at `wr_full` or `wr_overflow` within a few sensor clocks of the eighth or ninth queued word. The sweeps cover every tag pattern, groups broken up by invalid samples, the full/overflow boundary and a reset taken in mid-group.

// File: rtl/spf_pkg.sv
// Shared constants and the packed word type for the sensor packing FIFO.
package spf_pkg;
    localparam int SAMPLE_W = 16;
    localparam int LANES    = 4;
    localparam int LANE_W   = $clog2(LANES);
    localparam int WORD_W   = SAMPLE_W * LANES;

    typedef struct packed {
        logic [LANES-1:0]  tags;
        logic [WORD_W-1:0] data;
    } word_t;
endpackage

// File: rtl/spf_packer.sv
// Gathers LANES valid samples into one word, first sample in the lowest
// field. Emits a one-cycle strobe with the finished word.
// Assumes one sample per clock at most; invalid samples are skipped.
module spf_packer
    import spf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] s_data,
    input  logic                s_tag,
    input  logic                s_valid,
    output word_t               w_word,
    output logic                w_vld
);
    logic [LANE_W-1:0] lane;
    word_t             acc;
    word_t             acc_nx;

    // Merge the incoming sample into the current lane of the accumulator.
    always_comb begin
        acc_nx = acc;
        acc_nx.data[lane*SAMPLE_W +: SAMPLE_W] = s_data;
        acc_nx.tags[lane] = s_tag;
    end

    // Advance the lane counter and release a word after the last lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane   <= '0;
            acc    <= '0;
            w_word <= '0;
            w_vld  <= 1'b0;
        end else begin
            w_vld <= 1'b0;
            if (s_valid) begin
                acc <= acc_nx;
                if (lane == LANE_W'(LANES-1)) begin
                    lane   <= '0;
                    w_word <= acc_nx;
                    w_vld  <= 1'b1;
                end else begin
                    lane <= lane + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spf_sync.sv
// Multi-flop synchronizer for a Gray-coded pointer entering a clock domain.
// Assumes the source changes at most one bit per source clock.
module spf_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    // Shift the foreign value through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st[i] <= '0;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/spf_wr_ctrl.sv
// Write-side pointer logic: binary and Gray pointers, full flag from the
// synchronized read pointer, sticky overflow. Assumes AW >= 2.
module spf_wr_ctrl #(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW:0]   rgray_s,
    output logic [AW:0]   wbin,
    output logic [AW:0]   wgray,
    output logic          full,
    output logic          ovf,
    output logic          wen
);
    logic [AW:0] wbin_nx;

    assign wbin_nx = wbin + 1'b1;
    assign full    = (wgray == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
    assign wen     = push && !full;

    // Step the pointers on an accepted push; latch any dropped push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
            ovf   <= 1'b0;
        end else begin
            if (wen) begin
                wbin  <= wbin_nx;
                wgray <= wbin_nx ^ (wbin_nx >> 1);
            end
            if (push && full) ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/spf_rd_ctrl.sv
// Read-side pointer logic: empty flag from the synchronized write pointer,
// pointer advance on a completed handshake only.
module spf_rd_ctrl #(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ready,
    input  logic [AW:0]   wgray_s,
    output logic [AW:0]   rbin,
    output logic [AW:0]   rgray,
    output logic          empty
);
    logic [AW:0] rbin_nx;
    logic        pop;

    assign rbin_nx = rbin + 1'b1;
    assign empty   = (rgray == wgray_s);
    assign pop     = ready && !empty;

    // Step the pointers when a word is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (pop) begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end
endmodule

// File: rtl/sensor_pack_fifo.sv
// Top: packs tagged sensor samples into wide words and carries them from
// the sensor clock into the core clock through a Gray-pointer FIFO.
// Assumes the two clocks are unrelated and each reset is synchronous.
module sensor_pack_fifo
    import spf_pkg::*;
#(
    parameter int AW        = 3,
    parameter int SYNC_STGS = 2
) (
    input  logic                in_clk,
    input  logic                in_rst_n,
    input  logic [SAMPLE_W-1:0] in_data,
    input  logic                in_tag,
    input  logic                in_valid,
    output logic                wr_full,
    output logic                wr_overflow,
    input  logic                core_clk,
    input  logic                core_rst_n,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [WORD_W-1:0]   out_data,
    output logic [LANES-1:0]    out_tags
);
    localparam int DEPTH = 1 << AW;

    word_t       pk_word;
    logic        pk_vld;
    logic        wen;
    logic [AW:0] wbin, wgray, wgray_s;
    logic [AW:0] rbin, rgray, rgray_s;
    logic        rd_empty;
    word_t       mem [DEPTH];
    word_t       rd_word;

    spf_packer u_pack (
        .clk(in_clk), .rst_n(in_rst_n),
        .s_data(in_data), .s_tag(in_tag), .s_valid(in_valid),
        .w_word(pk_word), .w_vld(pk_vld)
    );

    spf_wr_ctrl #(.AW(AW)) u_wr (
        .clk(in_clk), .rst_n(in_rst_n), .push(pk_vld), .rgray_s(rgray_s),
        .wbin(wbin), .wgray(wgray), .full(wr_full), .ovf(wr_overflow),
        .wen(wen)
    );

    spf_sync #(.W(AW+1), .STAGES(SYNC_STGS)) u_r2w (
        .clk(in_clk), .rst_n(in_rst_n), .d(rgray), .q(rgray_s)
    );

    spf_sync #(.W(AW+1), .STAGES(SYNC_STGS)) u_w2r (
        .clk(core_clk), .rst_n(core_rst_n), .d(wgray), .q(wgray_s)
    );

    spf_rd_ctrl #(.AW(AW)) u_rd (
        .clk(core_clk), .rst_n(core_rst_n), .ready(out_ready),
        .wgray_s(wgray_s), .rbin(rbin), .rgray(rgray), .empty(rd_empty)
    );

    // Store each accepted word in the slot named by the write pointer.
    always_ff @(posedge in_clk) begin
        if (wen) mem[wbin[AW-1:0]] <= pk_word;
    end

    assign rd_word   = mem[rbin[AW-1:0]];
    assign out_valid = !rd_empty;
    assign out_data  = rd_word.data;
    assign out_tags  = rd_word.tags;
endmodule

// File: rtl/spf_checker.sv
// Temporal checks for sensor_pack_fifo, attached with bind.
module spf_checker
    import spf_pkg::*;
#(
    parameter int AW = 3
) (
    input logic              in_clk,
    input logic              in_rst_n,
    input logic              core_clk,
    input logic              core_rst_n,
    input logic              pk_vld,
    input logic              wr_full,
    input logic              wr_overflow,
    input logic [AW:0]       wbin,
    input logic [AW:0]       wgray,
    input logic [AW:0]       rbin,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic [LANES-1:0]  out_tags
);
    // R1: reset drives the write pointer to zero
    p_wptr_reset_r1: assert property (@(posedge in_clk)
        !in_rst_n |=> (wbin == '0));

    // R1: reset drives the read pointer to zero
    p_rptr_reset_r1: assert property (@(posedge core_clk)
        !core_rst_n |=> (rbin == '0));

    // R5: an offered word holds until taken
    p_hold_word_r5: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_tags)));

    // R5: write pointer crosses with a single-bit Gray step
    p_gray_step_r5: assert property (@(posedge in_clk) disable iff (!in_rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    // R6: a word completed while full does not move the write pointer
    p_no_overflow_r6: assert property (@(posedge in_clk) disable iff (!in_rst_n)
        (pk_vld && wr_full) |=> $stable(wbin));

    // R6: overflow is sticky
    p_ovf_sticky_r6: assert property (@(posedge in_clk) disable iff (!in_rst_n)
        wr_overflow |=> wr_overflow);

    // R7: ready while empty leaves the read pointer alone
    p_empty_idle_r7: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        !out_valid |=> $stable(rbin));
endmodule

bind sensor_pack_fifo spf_checker #(.AW(AW)) u_chk (
    .in_clk(in_clk), .in_rst_n(in_rst_n),
    .core_clk(core_clk), .core_rst_n(core_rst_n),
    .pk_vld(pk_vld), .wr_full(wr_full), .wr_overflow(wr_overflow),
    .wbin(wbin), .wgray(wgray), .rbin(rbin),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_tags(out_tags)
);

// File: tb/tb_sensor_pack_fifo.sv
module tb_sensor_pack_fifo;
    localparam int IN_PERIOD   = 64;
    localparam int CORE_PERIOD = 60;
    localparam int DEPTH       = 8;

    logic        in_clk = 1'b0, core_clk = 1'b0;
    logic        in_rst_n = 1'b0, core_rst_n = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_tag = 1'b0, in_valid = 1'b0;
    logic        wr_full, wr_overflow, out_valid;
    logic        out_ready = 1'b0;
    logic [63:0] out_data;
    logic [3:0]  out_tags;

    int checks = 0, fails = 0;
    int wcnt = 0, rcnt = 0;
    int smp_idx = 0;
    bit done = 0;
    logic [63:0] exp_d [64];
    logic [3:0]  exp_t [64];

    sensor_pack_fifo dut (
        .in_clk(in_clk), .in_rst_n(in_rst_n), .in_data(in_data),
        .in_tag(in_tag), .in_valid(in_valid), .wr_full(wr_full),
        .wr_overflow(wr_overflow), .core_clk(core_clk),
        .core_rst_n(core_rst_n), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_tags(out_tags)
    );

    always #(IN_PERIOD/2)   in_clk   = ~in_clk;
    always #(CORE_PERIOD/2) core_clk = ~core_clk;

    function automatic logic [15:0] smp(int k);
        return 16'((k * 40503) ^ 16'h5A5A);
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic in_idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge in_clk);
            in_valid = 1'b0;
        end
    endtask

    // Sends four valid samples; gap inserts an invalid junk sample before each.
    task automatic send_word(logic [3:0] tags, bit gap, bit record);
        logic [63:0] d;
        d = '0;
        for (int l = 0; l < 4; l++) begin
            if (gap) begin
                @(negedge in_clk);
                in_valid = 1'b0; in_data = 16'hDEAD; in_tag = ~tags[l];
            end
            @(negedge in_clk);
            in_valid = 1'b1; in_data = smp(smp_idx); in_tag = tags[l];
            d[l*16 +: 16] = smp(smp_idx);
            smp_idx++;
        end
        @(negedge in_clk);
        in_valid = 1'b0;
        if (record) begin
            exp_d[wcnt % 64] = d;
            exp_t[wcnt % 64] = tags;
            wcnt++;
        end
    endtask

    task automatic read_word(string req);
        int w;
        w = 0;
        @(negedge core_clk);
        while (!out_valid && w < 400) begin
            @(negedge core_clk);
            w++;
        end
        chk(out_valid, req, {63'd0, out_valid}, 64'd1);
        chk(out_data == exp_d[rcnt % 64], req, out_data, exp_d[rcnt % 64]);
        chk(out_tags == exp_t[rcnt % 64], req, {60'd0, out_tags}, {60'd0, exp_t[rcnt % 64]});
        out_ready = 1'b1;
        @(posedge core_clk);
        #1 out_ready = 1'b0;
        rcnt++;
    endtask

    task automatic do_reset();
        in_rst_n = 1'b0; core_rst_n = 1'b0;
        repeat (4) @(negedge in_clk);
        in_valid = 1'b0;
        in_rst_n = 1'b1; core_rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(IN_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        do_reset();
        in_idle(4);
        // R1: idle state after reset
        chk(!out_valid, "R1 valid", {63'd0, out_valid}, 64'd0);
        chk(!wr_full, "R1 full", {63'd0, wr_full}, 64'd0);
        chk(!wr_overflow, "R1 ovf", {63'd0, wr_overflow}, 64'd0);

        // R2 R3 R4 R5: every tag pattern, some groups broken by invalid samples
        fork
            for (int w = 0; w < 16; w++) send_word(4'(w), (w % 3) == 0, 1'b1);
            for (int w = 0; w < 16; w++) read_word("R2 R3 R4 R5 sweep");
        join

        // R7: ready while empty has no effect
        @(negedge core_clk);
        out_ready = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge core_clk);
            chk(!out_valid, "R7 idle", {63'd0, out_valid}, 64'd0);
        end
        out_ready = 1'b0;
        send_word(4'b1010, 1'b0, 1'b1);
        read_word("R7 next word");

        // R6: fill to depth, then one extra word is dropped
        for (int w = 0; w < DEPTH; w++) send_word(4'(w + 3), 1'b0, 1'b1);
        in_idle(4);
        chk(wr_full, "R6 full", {63'd0, wr_full}, 64'd1);
        chk(!wr_overflow, "R6 no ovf yet", {63'd0, wr_overflow}, 64'd0);
        send_word(4'b1111, 1'b0, 1'b0);
        in_idle(3);
        chk(wr_overflow, "R6 ovf set", {63'd0, wr_overflow}, 64'd1);
        for (int w = 0; w < DEPTH; w++) read_word("R5 R6 drain");
        repeat (10) @(negedge core_clk);
        chk(!out_valid, "R5 empty after drain", {63'd0, out_valid}, 64'd0);
        in_idle(6);
        chk(!wr_full, "R6 full clears", {63'd0, wr_full}, 64'd1 - 64'd1);
        chk(wr_overflow, "R6 ovf sticky", {63'd0, wr_overflow}, 64'd1);

        // R1: reset with unread words and a half-built group
        send_word(4'b0001, 1'b0, 1'b0);
        send_word(4'b0010, 1'b0, 1'b0);
        for (int l = 0; l < 2; l++) begin
            @(negedge in_clk);
            in_valid = 1'b1; in_data = 16'hBEEF; in_tag = 1'b1;
        end
        @(negedge in_clk);
        in_valid = 1'b0;
        do_reset();
        in_idle(4);
        chk(!out_valid, "R1 valid after reset", {63'd0, out_valid}, 64'd0);
        chk(!wr_full, "R1 full after reset", {63'd0, wr_full}, 64'd0);
        chk(!wr_overflow, "R1 ovf after reset", {63'd0, wr_overflow}, 64'd0);
        rcnt = wcnt;
        send_word(4'b0110, 1'b1, 1'b1);
        read_word("R1 first word after reset");
        repeat (6) @(negedge core_clk);
        chk(!out_valid, "R1 single word", {63'd0, out_valid}, 64'd0);

        finish_run();
    end
endmodule